// File: doc/BRIEF.md
# Keyboard Interrupt Controller

This block watches a small group of active-low key inputs and condenses them into one pending flag and one interrupt request. Software chooses which pins take part with a per-pin enable byte. A control byte picks between two detection styles, masks the request globally and clears the flag through a write-one acknowledge bit. Each pin passes through a synchronizer before any detection. Detection runs on the same clock as everything else, so the block keeps working when the processor is idle. A wake request output mirrors the interrupt request so that a low-power controller can restart the core.

Two detection styles exist. In edge mode the flag latches on a high-to-low transition of an enabled, synchronized pin. In edge-plus-level mode the flag is also forced while any enabled pin stays low, so an acknowledge only holds once every enabled pin is released. A debug break input can protect the flag: while the break is active and the clear-permit input is low, acknowledge writes are dropped. When the clear-permit input is high, an acknowledge during the break clears the flag for good.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, the enable byte reads 0x00, the control byte reads 0x02 (mask set, edge mode, flag clear), and irq_req and wake_req are 0.
- R2: Register map. Address 0 is the control byte: bit 3 is the read-only pending flag, bit 2 is the write-only acknowledge, bit 1 is the mask and bit 0 is the mode (0 = edge only, 1 = edge plus level). Address 1 holds one enable bit per pin, with bit i enabling pin i.
- R3: In edge mode, a high-to-low change on an enabled pin sets the flag by the third rising clock edge after the pin changes.
- R4: A pin whose enable bit is 0 never sets the flag. A pin that is already low when it becomes enabled does not set the flag in edge mode. A low-to-high change never sets the flag.
- R5: irq_req is 1 exactly when the flag is 1 and the mask is 0. With the mask set the flag still sets, but irq_req stays 0.
- R6: Writing address 0 with bit 2 set clears the flag. Bit 2 always reads back as 0.
- R7: In edge-plus-level mode, the flag sets again on the next cycle while any enabled pin is low, so an acknowledge only holds after all enabled pins are high.
- R8: If an acknowledge and a new qualifying edge fall on the same clock edge, the flag ends at 1.
- R9: While dbg_break is 1 and dbg_clr_en is 0, acknowledge writes leave the flag unchanged.
- R10: While dbg_break is 1 and dbg_clr_en is 1, an acknowledge clears the flag, and the flag stays 0 after the break ends.
- R11: wake_req always equals irq_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_pin_n | input | NPINS | Active-low key inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| dbg_break | input | 1 | Debug break state is active |
| dbg_clr_en | input | 1 | Permits flag clearing during break |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake request for low-power modes |

## Verification
The bench puts an acknowledge on the same clock edge as a fresh edge on a second pin. A design that gives the clear priority would lose that key press. It enables a pin that is already low and expects no flag, which catches an edge detector that does not track the pin while it is disabled. In edge-plus-level mode it acknowledges while a pin is held low and expects the flag back. This catches a design that treats both modes alike. Both break cases are run: one protects a set flag from an acknowledge, and one lets the acknowledge clear the flag and keep it clear after the break ends.

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl #(
  parameter int NPINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] kbd_pin_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             dbg_break,
  input  logic             dbg_clr_en,
  output logic             irq_req,
  output logic             wake_req
);
  localparam int FLAG_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pin_act;
  logic [NPINS-1:0] edge_hit;
  logic             mask_q, mode_q, flag_q;
  logic             set_req, ack_req;
  logic [7:0]       en_rd;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '1;
        hist_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[SYNC_STAGES-2:0], kbd_pin_n[i]};
        hist_q <= ~sh_q[SYNC_STAGES-1];
      end
    end
    assign pin_act[i]  = ~sh_q[SYNC_STAGES-1];
    assign edge_hit[i] = en_q[i] & pin_act[i] & ~hist_q;
  end

  assign set_req = (|edge_hit) | (mode_q & |(en_q & pin_act));
  assign ack_req = reg_wr & ~reg_addr & reg_wdata[ACK_BIT] & (~dbg_break | dbg_clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= 1'b1;
      mode_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr) en_q <= reg_wdata[NPINS-1:0];
      else begin
        mask_q <= reg_wdata[MASK_BIT];
        mode_q <= reg_wdata[MODE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (ack_req) flag_q <= 1'b0;
  end

  always_comb begin
    en_rd = '0;
    en_rd[NPINS-1:0] = en_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata = en_rd;
    else begin
      reg_rdata[FLAG_BIT] = flag_q;
      reg_rdata[MASK_BIT] = mask_q;
      reg_rdata[MODE_BIT] = mode_q;
    end
  end

  assign irq_req  = flag_q & ~mask_q;
  assign wake_req = flag_q & ~mask_q;
endmodule

// File: rtl/kbd_irq_ctrl_chk.sv
module kbd_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       dbg_break,
  input logic       dbg_clr_en,
  input logic       irq_req,
  input logic       wake_req,
  input logic       flag,
  input logic       mask,
  input logic       set_req
);
  logic ack_wr;
  assign ack_wr = reg_wr && !reg_addr && reg_wdata[2];

  AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (!mask && flag)); // R5
  AST_WAKE_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) wake_req == irq_req); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_req |=> flag); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (!dbg_break || dbg_clr_en) && !set_req) |=> !flag); // R6
  AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_break && !dbg_clr_en && flag) |=> flag); // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !flag) |=> !flag); // R4

  always_comb begin
    if (rst_n && !reg_addr) AST_ACK_READS_ZERO: assert (reg_rdata[2] == 1'b0); // R6
  end
endmodule

bind kbd_irq_ctrl kbd_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_break(dbg_break),
  .dbg_clr_en(dbg_clr_en), .irq_req(irq_req), .wake_req(wake_req),
  .flag(flag_q), .mask(mask_q), .set_req(set_req)
);

// File: tb/tb_kbd_irq_ctrl.sv
`timescale 1ns/1ps
module tb_kbd_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pins = 8'hFF;
  logic       wr = 0, addr = 0, brk = 0, clr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq, wake;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  kbd_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .kbd_pin_n(pins), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .dbg_break(brk), .dbg_clr_en(clr_en),
    .irq_req(irq), .wake_req(wake)
  );

  always #5 clk = ~clk;

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
    wr = 0; wdata = 0; addr = 0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 0;
  endtask

  function automatic logic [7:0] flag_of(input logic [7:0] st);
    return {7'b0, st[3]};
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    rreg(0, d); chk("R1 ctrl", d, 8'h02);
    rreg(1, d); chk("R1 enable", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 0);
    chk("R1 wake", {7'b0, wake}, 0);
  endtask

  task automatic t_init_and_edge;
    logic [7:0] d;
    wreg(1, 8'hFF); wreg(0, 8'h06); wreg(0, 8'h00);
    rreg(1, d); chk("R2 enable readback", d, 8'hFF);
    rreg(0, d); chk("R2 ctrl after init", d, 8'h00);
    pins[3] = 0; tick(2);
    rreg(0, d); chk("R3 not yet set after two edges", flag_of(d), 0);
    tick();
    rreg(0, d); chk("R3 edge sets flag", flag_of(d), 1);
    chk("R5 irq when unmasked", {7'b0, irq}, 1);
    chk("R11 wake follows irq", {7'b0, wake}, 1);
    wreg(0, 8'h04);
    rreg(0, d); chk("R6 ack clears, bit2 reads 0", d, 8'h00);
    tick(3);
    rreg(0, d); chk("R3 edge mode stays clear while pin low", flag_of(d), 0);
    pins[3] = 1; tick(4);
    rreg(0, d); chk("R4 rising edge ignored", flag_of(d), 0);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wreg(0, 8'h02);
    pins[5] = 0; tick(4);
    rreg(0, d); chk("R5 flag sets while masked", flag_of(d), 1);
    chk("R5 irq held off by mask", {7'b0, irq}, 0);
    chk("R11 wake held off by mask", {7'b0, wake}, 0);
    wreg(0, 8'h00);
    chk("R5 irq after unmask", {7'b0, irq}, 1);
    wreg(0, 8'h04); pins[5] = 1; tick(4);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wreg(1, 8'hFE);
    pins[0] = 0; tick(5);
    rreg(0, d); chk("R4 disabled pin ignored", flag_of(d), 0);
    wreg(1, 8'hFF); tick(4);
    rreg(0, d); chk("R4 stale low on enable ignored", flag_of(d), 0);
    pins[0] = 1; tick(4);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wreg(0, 8'h01);
    pins[6] = 0; tick(4);
    rreg(0, d); chk("R7 level mode sets", d, 8'h09);
    wreg(0, 8'h05); tick();
    rreg(0, d); chk("R7 ack does not hold while pin low", flag_of(d), 1);
    pins[6] = 1; tick(4);
    wreg(0, 8'h05); tick(2);
    rreg(0, d); chk("R7 ack holds after release", flag_of(d), 0);
    wreg(0, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    pins[1] = 0; tick(4);
    pins[2] = 0; tick(2);
    wreg(0, 8'h04);
    rreg(0, d); chk("R8 set beats same-cycle ack", flag_of(d), 1);
    wreg(0, 8'h04);
    rreg(0, d); chk("R6 later ack clears", flag_of(d), 0);
    pins[1] = 1; pins[2] = 1; tick(4);
  endtask

  task automatic t_break;
    logic [7:0] d;
    pins[4] = 0; tick(4);
    brk = 1; clr_en = 0;
    wreg(0, 8'h04);
    rreg(0, d); chk("R9 ack ignored in protected break", flag_of(d), 1);
    brk = 0; wreg(0, 8'h04);
    rreg(0, d); chk("R9 ack works after break", flag_of(d), 0);
    pins[4] = 1; tick(4); pins[4] = 0; tick(4);
    rreg(0, d); chk("R3 second edge sets", flag_of(d), 1);
    brk = 1; clr_en = 1;
    wreg(0, 8'h04);
    rreg(0, d); chk("R10 ack clears in permitted break", flag_of(d), 0);
    brk = 0; clr_en = 0; tick(3);
    rreg(0, d); chk("R10 flag stays clear after break", flag_of(d), 0);
    pins[4] = 1; tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_init_and_edge();
    t_mask();
    t_disabled();
    t_level();
    t_set_wins();
    t_break();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule